// File: doc/BRIEF.md
# Chained LFSR Byte Substitution Layer

This block replaces a table-driven byte substitution with a 128-bit substitution built from sixteen small linear feedback shift register lanes. Each 8-bit lane takes its own input byte, XORs it with the result of the lane below it, loads that value as the seed of an 8-bit shift register, and advances the register a fixed number of steps through a combinational unroll. The value left in the register is the lane result. That result also feeds the next lane up. The chain starts at the least-significant byte.

A parameter chooses the shift register form. Fibonacci form feeds the XOR of the tapped bits back into the top bit. Galois form toggles the tapped bits when the bit shifted out is 1. Both forms use the polynomial x^8 + x^6 + x^5 + x^4 + 1. The whole chain settles inside one clock period. The 128-bit result is captured in a register together with a valid flag. A caller presents a state word with a one-cycle strobe and collects the substituted word one cycle later. Back-to-back words are accepted every cycle.

Top module: `lfsr_sub_layer`

## Requirements
- R1: Output byte i (bits 8i+7..8i) depends only on input bytes 0..i. Changing the top input byte leaves output bytes 0..14 unchanged.
- R2: With GALOIS=0, one step maps state s to {s[0]^s[2]^s[3]^s[4], s[7:1]}. The feedback bit enters bit 7 and the register shifts toward bit 0.
- R3: With GALOIS=1, one step maps state s to (s>>1) XOR (s[0] ? 8'hB8 : 8'h00).
- R4: The seed of lane i is input byte i XOR the result of lane i-1. The seed of lane 0 is input byte 0 alone. The result of lane i is output byte i.
- R5: Each lane applies exactly STEPS steps to its seed (default 8).
- R6: When in_valid is high at a clock edge and reset is low, out_valid is high after that edge and out_data holds the substituted word. Words presented on consecutive cycles each appear on consecutive cycles.
- R7: When in_valid is low at a clock edge, out_valid is low after it and out_data keeps its previous value, whatever in_data carries.
- R8: An all-zero input word yields an all-zero output word.
- R9: Synchronous active-high reset clears out_data to zero and out_valid to 0. Reset takes priority over an in_valid that arrives in the same cycle.
- R10: For fixed upper bytes, the 256 values of input byte 0 give 256 distinct values of output byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: in_data is to be substituted |
| in_data | input | 128 | State word, byte 0 in bits 7..0 |
| out_valid | output | 1 | Registered result is fresh this cycle |
| out_data | output | 128 | Registered substituted word |

## Verification
Two functions can fall in the same cycle: reset and acceptance of a new word. The bench raises reset while in_valid is high and carries a random nonzero word. It then expects the cleared state, a zero word with out_valid low, on the following cycle and not the substituted value. The bench also interleaves idle cycles that carry junk data with back-to-back valid cycles. This shows that a capture in one cycle and a hold in the next never mix.

// File: rtl/lfsr_sub_pkg.sv
package lfsr_sub_pkg;

  localparam int unsigned LANE_BITS = 8;

  // Feedback selection for the right-shifting Fibonacci register (bits 0,2,3,4)
  localparam logic [LANE_BITS-1:0] FIB_TAP_MASK = 8'h1D;
  // Toggle mask for the right-shifting Galois register
  localparam logic [LANE_BITS-1:0] GAL_TAP_MASK = 8'hB8;

  typedef enum logic {LFSR_FIB = 1'b0, LFSR_GAL = 1'b1} lfsr_form_e;

endpackage

// File: rtl/lfsr_sub_lane.sv
module lfsr_sub_lane #(
  parameter int unsigned              W        = 8,
  parameter int unsigned              STEPS    = 8,
  parameter bit                       GALOIS   = 1'b0,
  parameter logic [W-1:0]             FIB_MASK = 8'h1D,
  parameter logic [W-1:0]             GAL_MASK = 8'hB8
) (
  input  logic [W-1:0] lane_in,
  input  logic [W-1:0] carry_in,
  output logic [W-1:0] lane_out
);

  logic [W-1:0] stage [0:STEPS];

  assign stage[0] = lane_in ^ carry_in;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    if (GALOIS) begin : g_gal
      assign stage[k+1] = (stage[k] >> 1) ^ (stage[k][0] ? GAL_MASK : '0);
    end else begin : g_fib
      assign stage[k+1] = {^(stage[k] & FIB_MASK), stage[k][W-1:1]};
    end
  end

  assign lane_out = stage[STEPS];

endmodule

// File: rtl/lfsr_sub_chain.sv
module lfsr_sub_chain
  import lfsr_sub_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned STEPS  = 8,
  parameter bit          GALOIS = 1'b0,
  localparam int unsigned W      = LANE_BITS,
  localparam int unsigned DATA_W = LANES * W
) (
  input  logic [DATA_W-1:0] chain_in,
  output logic [DATA_W-1:0] chain_out
);

  // carry[i] feeds lane i; carry[0] is the zero start of the chain
  logic [W-1:0] carry [0:LANES];

  assign carry[0] = '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lfsr_sub_lane #(
      .W       (W),
      .STEPS   (STEPS),
      .GALOIS  (GALOIS),
      .FIB_MASK(FIB_TAP_MASK),
      .GAL_MASK(GAL_TAP_MASK)
    ) u_lane (
      .lane_in (chain_in[i*W +: W]),
      .carry_in(carry[i]),
      .lane_out(carry[i+1])
    );
    assign chain_out[i*W +: W] = carry[i+1];
  end

endmodule

// File: rtl/lfsr_sub_layer.sv
module lfsr_sub_layer
  import lfsr_sub_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned STEPS  = 8,
  parameter bit          GALOIS = 1'b0,
  localparam int unsigned DATA_W = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] sub_word;

  lfsr_sub_chain #(
    .LANES (LANES),
    .STEPS (STEPS),
    .GALOIS(GALOIS)
  ) u_chain (
    .chain_in (in_data),
    .chain_out(sub_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sub_word;
    end
  end

endmodule

// File: rtl/lfsr_sub_layer_chk.sv
module lfsr_sub_layer_chk #(
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R6: accepted word is flagged on the next cycle
  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7: idle cycle leaves no valid flag and keeps the data
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R8: zero word maps to zero word
  assert_zero_passthru_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> (out_data == '0));

  // R9: the cycle after reset shows the cleared state
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R9: assert (out_valid == 1'b0 && out_data == '0);
    end
  end

endmodule

bind lfsr_sub_layer lfsr_sub_layer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/lfsr_sub_layer_bench.sv
module lfsr_sub_layer_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         vf, vg;
  logic [127:0] df, dg;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit armed = 0;
  logic         exp_v;
  logic [127:0] exp_f, exp_g;

  always #2 clk = ~clk;

  lfsr_sub_layer #(.GALOIS(1'b0)) u_lfsr_sub_layer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(vf), .out_data(df));

  lfsr_sub_layer #(.GALOIS(1'b1)) u_lfsr_sub_layer_gal (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(vg), .out_data(dg));

  // R2 step
  function automatic logic [7:0] fib_step(input logic [7:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]};
  endfunction

  // R3 step
  function automatic logic [7:0] gal_step(input logic [7:0] s);
    return (s >> 1) ^ (s[0] ? 8'hB8 : 8'h00);
  endfunction

  // R4/R5 chained model
  function automatic logic [127:0] model(input logic [127:0] d, input bit gal);
    logic [127:0] r;
    logic [7:0] c, s;
    c = 8'h00;
    for (int i = 0; i < 16; i++) begin
      s = d[8*i +: 8] ^ c;
      for (int k = 0; k < 8; k++) s = gal ? gal_step(s) : fib_step(s);
      r[8*i +: 8] = s;
      c = s;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: check the result of the previous cycle, then drive new inputs
  task automatic cyc(input logic r, input logic v, input logic [127:0] d, input string tag);
    @(negedge clk);
    if (armed) begin
      chk({tag, " fib valid"}, {127'd0, vf}, {127'd0, exp_v});
      chk({tag, " fib data"},  df, exp_f);
      chk({tag, " gal valid"}, {127'd0, vg}, {127'd0, exp_v});
      chk({tag, " gal data"},  dg, exp_g);
    end
    rst = r; in_valid = v; in_data = d;
    if (r) begin
      exp_v = 1'b0; exp_f = '0; exp_g = '0;
    end else if (v) begin
      exp_v = 1'b1; exp_f = model(d, 1'b0); exp_g = model(d, 1'b1);
    end else begin
      exp_v = 1'b0;
    end
    armed = 1;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit seen [0:255];
    int distinct;
    logic [127:0] base;
    void'($urandom(32'h5EED_0042));

    cyc(1, 0, '0, "R9");
    cyc(1, 0, '0, "R9");
    cyc(0, 0, rnd128(), "R9");          // reset state checked here
    cyc(0, 1, '0, "R9");
    cyc(0, 0, '0, "R8");                // zero word in -> zero word out
    cyc(0, 1, 128'h01, "R8");
    cyc(0, 0, rnd128(), "R4");          // single low byte ripples up the chain
    cyc(0, 0, rnd128(), "R7");          // idle with junk data holds
    base = rnd128();
    cyc(0, 1, base, "R7");
    cyc(0, 1, base ^ {8'hA5, 120'd0}, "R1");  // only top byte changed
    cyc(0, 1, rnd128(), "R1");          // back-to-back, R1 result checked here
    cyc(0, 0, '0, "R6");
    cyc(1, 1, rnd128(), "R6");          // reset and valid together
    cyc(0, 0, rnd128(), "R9");          // reset must win
    // random mix, both forms against the model (R2, R3, R5)
    for (int n = 0; n < 120; n++) begin
      cyc(0, ($urandom % 3) != 0, rnd128(), "R5");
    end
    cyc(0, 0, '0, "R5");
    // R10: sweep of byte 0 with fixed upper bytes
    foreach (seen[i]) seen[i] = 0;
    base = rnd128();
    for (int i = 0; i < 256; i++) begin
      cyc(0, 1, {base[127:8], i[7:0]}, "R10");
      if (i > 0) seen[df[7:0]] = 1;
    end
    cyc(0, 0, '0, "R10");
    seen[df[7:0]] = 1;
    distinct = 0;
    foreach (seen[i]) if (seen[i]) distinct++;
    chk("R10 distinct", 128'(distinct), 128'd256);
    cyc(0, 0, '0, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule